// File: doc/BRIEF.md
# Double-Buffered Block Deinterleaver Store

This block is the storage half of a block deinterleaver. It holds two equal memory banks that swap roles. Incoming bits or soft values are written into the fill bank, each at a permuted address that an external generator supplies with it. At the same time, the other bank, which holds the previous complete block, is read at ascending addresses and streamed out. When the last beat of a block has been written, the fill bank and the drain bank change places.

The drain side is paced by the fill side. Each accepted input beat also reads one stored entry of the previous block. No output appears until a whole block has been stored. The block length is taken from `blk_size` at the first beat of every block and may be any value from 1 to `MAX_DEPTH`. Consecutive blocks are expected to have the same length.

Top module: `pp_deint`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_valid` and `out_last` are 0.
- R2: No beat of `out_valid` is produced while the first block after reset is being written.
- R3: Once a block has been written, its entry at address k is the k-th value (counting from 0) streamed out during the next block. That entry is the `in_data` of the beat whose `in_addr` was k. The previous block's bank is never written while it is being read.
- R4: From the second block on, every accepted input beat produces exactly one output beat, with `out_valid` high in the clock after the beat is sampled.
- R5: `out_last` is high only together with `out_valid`, and exactly on the output beat at position `blk_size`-1 of each block.
- R6: A cycle with `in_valid` low produces no output and does not advance the position in the block or the bank roles.
- R7: The banks alternate on every block boundary. Back-to-back blocks come out each with its own contents, with no entries mixed between blocks.
- R8: The block length is sampled from `blk_size` at the first beat of each block. A change of `blk_size` during the other beats of that block has no effect. The position counter never passes `MAX_DEPTH`-1.
- R9: The extreme block lengths 1 and `MAX_DEPTH` work like any other length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| blk_size | input | SIZE_W | Block length, 1..MAX_DEPTH, sampled at the first beat of a block |
| in_valid | input | 1 | Input beat present |
| in_addr | input | ADDR_W | Permuted write address of the current beat |
| in_data | input | DATA_W | Bit or soft value of the current beat |
| out_valid | output | 1 | Output beat present |
| out_data | output | DATA_W | Deinterleaved value, in ascending address order |
| out_last | output | 1 | Marks the final output beat of a block |

## Verification
The output for an input beat is due one clock after the edge that samples that beat. That clock covers one register stage in the bank read port and the flag registers. The bench therefore drives a beat, waits for the sampling edge, and checks the outputs two time units after that same edge, before the next beat is applied. The expected value for position k of a block is the value the bench itself wrote at permuted address k one block earlier. Idle beats are checked for silence in the same slot.

// File: rtl/pp_deint_pkg.sv
package pp_deint_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic bank_e other_bank(bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int DATA_W = 1,
  parameter int DEPTH  = 576,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_deint_pkg::*;
#(
  parameter int DEPTH  = 576,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int SIZE_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SIZE_W-1:0] blk_size,
  output bank_e             wr_bank,
  output bank_e             rd_bank_q,
  output logic [ADDR_W-1:0] pos,
  output logic              rd_en,
  output logic              out_valid,
  output logic              out_last
);
  localparam int CW = SIZE_W + 1;

  logic [SIZE_W-1:0] size_q;
  logic [SIZE_W-1:0] eff_size;
  logic              primed;
  logic              end_beat;

  assign eff_size = (pos == '0) ? blk_size : size_q;
  assign end_beat = in_valid &&
                    ((CW'(pos) + CW'(1) == CW'(eff_size)) || (pos == ADDR_W'(DEPTH - 1)));
  assign rd_en    = in_valid && primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= '0;
      size_q    <= '0;
      wr_bank   <= BANK_A;
      rd_bank_q <= BANK_B;
      primed    <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= rd_en;
      out_last  <= rd_en && end_beat;
      rd_bank_q <= other_bank(wr_bank);
      if (in_valid) begin
        if (pos == '0) size_q <= blk_size;
        if (end_beat) begin
          pos     <= '0;
          wr_bank <= other_bank(wr_bank);
          primed  <= 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(pos) && $stable(wr_bank)));

  // R7
  swap_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_bank) |-> (pos == '0));

  // R8
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    pos < ADDR_W'(DEPTH));

  // R5
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R4
  out_follows_in_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
endmodule

// File: rtl/pp_deint.sv
module pp_deint
  import pp_deint_pkg::*;
#(
  parameter int DATA_W    = 1,
  parameter int MAX_DEPTH = 576,
  localparam int ADDR_W   = $clog2(MAX_DEPTH),
  localparam int SIZE_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] blk_size,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);
  localparam int NBANK = 2;

  bank_e             wr_bank, rd_bank_q;
  logic [ADDR_W-1:0] pos;
  logic              rd_en;
  logic [DATA_W-1:0] rdata [NBANK];
  logic [NBANK-1:0]  we, re;

  pp_ctrl #(.DEPTH(MAX_DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .blk_size(blk_size),
    .wr_bank(wr_bank), .rd_bank_q(rd_bank_q), .pos(pos), .rd_en(rd_en),
    .out_valid(out_valid), .out_last(out_last)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign we[b] = in_valid && (wr_bank == bank_e'(b));
    assign re[b] = rd_en && (wr_bank != bank_e'(b));

    pp_bank #(.DATA_W(DATA_W), .DEPTH(MAX_DEPTH), .ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .we(we[b]), .waddr(in_addr), .wdata(in_data),
      .re(re[b]), .raddr(pos), .rdata(rdata[b])
    );

    // R3
    bank_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      !(we[b] && re[b]));
  end

  assign out_data = rdata[rd_bank_q];
endmodule

// File: tb/tb_pp_deint.sv
`timescale 1ns/1ps
module tb_pp_deint;
  localparam int DW   = 8;
  localparam int MAXD = 576;
  localparam int AW   = $clog2(MAXD);
  localparam int SW   = $clog2(MAXD + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] blk_size = '0;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, out_last;
  logic [DW-1:0] out_data;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [2][MAXD];
  int bcnt, nblk;

  always #4 clk = ~clk;

  pp_deint #(.DATA_W(DW), .MAX_DEPTH(MAXD)) dut (
    .clk(clk), .rst(rst), .blk_size(blk_size), .in_valid(in_valid),
    .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (block %0d beat %0d)", req, act, exp, nblk, bcnt);
    end
  endtask

  function automatic int gcd(int a, int b);
    while (b != 0) begin
      int t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 valid in reset", out_valid, 0);
    chk("R1 last in reset", out_last, 0);
    rst = 1'b0;
    @(posedge clk); #2;
    chk("R1 valid after reset", out_valid, 0);
    chk("R1 last after reset", out_last, 0);
    bcnt = 0; nblk = 0;
  endtask

  // one clock: idle or data beat, then check the outputs it produced
  task automatic beat(int n, bit valid, int addr, int data);
    bit exp_v;
    int exp_d;
    bit exp_l;
    in_valid = valid;
    in_addr  = AW'(addr);
    in_data  = DW'(data);
    exp_v = valid && (nblk > 0);
    exp_d = exp_v ? int'(ref_mem[(nblk - 1) % 2][bcnt]) : 0;
    exp_l = exp_v && (bcnt == n - 1);
    if (valid) ref_mem[nblk % 2][addr] = DW'(data);
    @(posedge clk); #2;
    if (!valid) begin
      chk("R6 idle valid", out_valid, 0);
      chk("R6 idle last", out_last, 0);
    end else if (nblk == 0) begin
      chk("R2 no output in first block", out_valid, 0);
    end else begin
      chk("R4 valid per beat", out_valid, 1);
      chk("R3 R7 data order", out_data, exp_d);
      chk("R5 end flag", out_last, exp_l);
    end
    if (valid) begin
      bcnt++;
      if (bcnt == n) begin
        bcnt = 0;
        nblk++;
      end
    end
  endtask

  task automatic run_size(int n, int nb, bit idles, bit glitch);
    do_reset();
    blk_size = SW'(n);
    for (int b = 0; b < nb; b++) begin
      int s = n / 2 + 1 + b;
      int off = (b * 7) % n;
      while (gcd(s, n) != 1) s++;
      for (int k = 0; k < n; k++) begin
        int a = (k * s + off) % n;
        if (idles && (k % 5 == 3)) beat(n, 1'b0, 0, 0);
        // R8: mid-block change of blk_size must be ignored
        if (glitch && k == 5) blk_size = SW'(n / 2 + 1);
        beat(n, 1'b1, a, (b * 37 + k * 5 + 1) & 8'hFF);
        if (glitch && k == 5) blk_size = SW'(n);
      end
    end
    in_valid = 1'b0;
  endtask

  initial begin
    run_size(1, 4, 1'b0, 1'b0);    // R9 minimum length
    run_size(2, 4, 1'b1, 1'b0);
    run_size(3, 3, 1'b0, 1'b0);
    run_size(7, 3, 1'b1, 1'b0);
    run_size(16, 4, 1'b0, 1'b1);   // R8 blk_size glitch
    run_size(48, 3, 1'b1, 1'b0);
    run_size(MAXD, 3, 1'b0, 1'b0); // R9 maximum length
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule